// File: doc/BRIEF.md
# DMA Cache-Line Request Scheduler

This block is the per-channel issue stage of a DMA engine. It takes one descriptor at a time: a source address, a destination address, a byte length and one coherence flag each for the source side and the destination side. It then decides, in every arbitration slot the channel is granted, how many cache-line read requests and how many cache-line write requests to send. Reads fill a data queue of cache-line slots and writes drain it. The scheduler keeps its own count of slots held by outstanding reads and of lines that have returned but are not yet written. It never sends more reads than there are free slots, and never sends a write for a line that has not come back from memory.

Each request carries a 36-bit physical address, which is used directly with no translation, and a byte count. It also carries a snoop-enable bit taken from the matching descriptor coherence flag. A non-coherent side gets snoop-enable low. The controller has three states. `ST_IDLE` is the state after reset. `ST_RUN` is entered from `ST_IDLE` or `ST_DONE` when a descriptor is loaded. `ST_DONE` is entered from `ST_RUN` once no write bytes remain, and it is held until the next load.

Top module: `dma_line_sched`

## Requirements
- R1: On a granted slot in `ST_RUN` the number of read requests is the smallest of 2, the free slot count (QUEUE_SLOTS minus outstanding reads minus held lines), and the read lines still to go.
- R2: On a granted slot in `ST_RUN` the number of write requests is the smallest of 2, the held line count (lines returned through `line_ret` and not yet written), and the write lines still to go. A write is never sent ahead of returned data.
- R3: A read reserves its queue slot when it is issued. Outstanding reads plus held lines never exceed QUEUE_SLOTS, so with no returns a descriptor issues exactly QUEUE_SLOTS reads.
- R4: Requests appear on the outputs in the cycle after the clock edge that samples `slot_grant`, and only for that cycle. Valid bits fill from lane 0 upward, and there are no requests without a grant.
- R5: Request lane k carries the descriptor base address plus 64 times the number of lines already issued on that side, plus 64·k, modulo 2^36. Reads use the source address and writes use the destination address.
- R6: Each request's byte count is 64, except the last request on a side, which carries the remaining byte count (1 to 64).
- R7: `rd_snoop` is the inverse of the source non-coherent flag and `wr_snoop` is the inverse of the destination non-coherent flag, both as captured at load.
- R8: `done` goes high one cycle after the cycle in which the final write requests are shown, and stays high until the next load. A zero-length descriptor raises `done` two cycles after its load edge. While `done` is high no requests are shown.
- R9: `desc_load` in `ST_RUN` is ignored. Addresses, lengths and flags keep their current values.
- R10: After reset the state is `ST_IDLE`, all valid bits are low and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_load | input | 1 | Descriptor load strobe |
| desc_src_addr | input | ADDR_W | Source base address |
| desc_dst_addr | input | ADDR_W | Destination base address |
| desc_len | input | LEN_W | Transfer length in bytes |
| desc_src_nc | input | 1 | Source non-coherent flag |
| desc_dst_nc | input | 1 | Destination non-coherent flag |
| slot_grant | input | 1 | Arbitration slot granted this cycle |
| line_ret | input | 1 | One read line returned into the queue |
| rd_vld | output | MAXN | Read request valid per lane |
| rd_addr | output | MAXN×ADDR_W | Read request addresses |
| rd_bytes | output | MAXN×7 | Read request byte counts |
| rd_snoop | output | MAXN | Read snoop enable |
| wr_vld | output | MAXN | Write request valid per lane |
| wr_addr | output | MAXN×ADDR_W | Write request addresses |
| wr_bytes | output | MAXN×7 | Write request byte counts |
| wr_snoop | output | MAXN | Write snoop enable |
| done | output | 1 | Descriptor complete |

## Verification
The assertions assume that `line_ret` is pulsed only while at least one read is outstanding, at most once per cycle. If that assumption were broken, the slot accounting they check could underflow. The stimulus keeps within it by gating every random return on the bench's own count of outstanding reads. The stimulus also loads descriptors at random, including loads during `ST_RUN`, which must be ignored.

// File: rtl/dls_pkg.sv
package dls_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sched_state_e;
endpackage

// File: rtl/dls_ctrl.sv
module dls_ctrl
    import dls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic wr_zero,
    output logic busy,
    output logic done,
    output logic accept
);
    sched_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load)    state_d = ST_RUN;
            ST_RUN:  if (wr_zero) state_d = ST_DONE;
            ST_DONE: if (load)    state_d = ST_RUN;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state_q == ST_RUN);
        done   = (state_q == ST_DONE);
        accept = load && (state_q != ST_RUN);
    end

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R8
    AST_RUN_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load)); // R9
endmodule

// File: rtl/dls_occ.sv
module dls_occ #(
    parameter int SLOTS = 8,
    parameter int CW    = 4,
    parameter int NW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [NW-1:0] rd_n,
    input  logic [NW-1:0] wr_n,
    input  logic          line_ret,
    output logic [CW-1:0] free_cnt,
    output logic [CW-1:0] held_cnt
);
    logic [CW-1:0] outs_q, held_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            outs_q <= '0;
            held_q <= '0;
        end else begin
            outs_q <= outs_q + CW'(rd_n) - CW'(line_ret);
            held_q <= held_q + CW'(line_ret) - CW'(wr_n);
        end
    end

    assign free_cnt = CW'(SLOTS) - outs_q - held_q;
    assign held_cnt = held_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(outs_q) + int'(held_q)) <= SLOTS); // R3
    AST_NO_WRITE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_n) <= int'(held_q)); // R2
    AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_n) <= int'(free_cnt)); // R1
endmodule

// File: rtl/dls_lane.sv
module dls_lane #(
    parameter int ADDR_W = 36,
    parameter int LEN_W  = 16,
    parameter int LINE_B = 64,
    parameter int MAXN   = 2,
    parameter int CW     = 4,
    parameter int NW     = 2,
    parameter int BW     = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [ADDR_W-1:0]          load_addr,
    input  logic [LEN_W-1:0]           load_len,
    input  logic                       load_nc,
    input  logic                       fire,
    input  logic [CW-1:0]              budget,
    output logic [MAXN-1:0]            req_vld,
    output logic [MAXN-1:0][ADDR_W-1:0] req_addr,
    output logic [MAXN-1:0][BW-1:0]    req_bytes,
    output logic [MAXN-1:0]            req_snoop,
    output logic [NW-1:0]              n_issue,
    output logic                       left_zero
);
    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  left_q;
    logic              nc_q;
    logic [MAXN-1:0]   elig;
    logic [LEN_W-1:0]  span;

    always_comb begin
        for (int k = 0; k < MAXN; k++) begin
            elig[k] = fire && (int'(budget) > k) && (left_q > LEN_W'(k * LINE_B));
        end
        n_issue = NW'($countones(elig));
        span    = LEN_W'(n_issue) * LEN_W'(LINE_B);
    end

    assign left_zero = (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            left_q <= '0;
            nc_q   <= 1'b0;
        end else if (load) begin
            ptr_q  <= load_addr;
            left_q <= load_len;
            nc_q   <= load_nc;
        end else if (n_issue != '0) begin
            ptr_q  <= ptr_q + ADDR_W'(span);
            left_q <= (left_q <= span) ? '0 : left_q - span;
        end
    end

    for (genvar k = 0; k < MAXN; k++) begin : g_req
        logic              vld_q;
        logic [ADDR_W-1:0] addr_q;
        logic [BW-1:0]     bytes_q;
        logic              snoop_q;
        logic [LEN_W-1:0]  rem_k;

        assign rem_k = left_q - LEN_W'(k * LINE_B);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q   <= 1'b0;
                addr_q  <= '0;
                bytes_q <= '0;
                snoop_q <= 1'b0;
            end else begin
                vld_q   <= elig[k];
                addr_q  <= ptr_q + ADDR_W'(k * LINE_B);
                bytes_q <= !elig[k] ? '0 :
                           (rem_k >= LEN_W'(LINE_B)) ? BW'(LINE_B) : BW'(rem_k);
                snoop_q <= elig[k] & ~nc_q;
            end
        end

        assign req_vld[k]   = vld_q;
        assign req_addr[k]  = addr_q;
        assign req_bytes[k] = bytes_q;
        assign req_snoop[k] = snoop_q;

        AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q |-> (bytes_q != '0 && int'(bytes_q) <= LINE_B)); // R6
        if (k > 0) begin : g_pack
            AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q |-> req_vld[k-1]); // R4
        end
    end

    AST_REQ_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vld) |-> $past(fire)); // R4
endmodule

// File: rtl/dma_line_sched.sv
module dma_line_sched #(
    parameter int ADDR_W = 36,
    parameter int LEN_W  = 16,
    parameter int LINE_B = 64,
    parameter int MAXN   = 2,
    parameter int SLOTS  = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      desc_load,
    input  logic [ADDR_W-1:0]                         desc_src_addr,
    input  logic [ADDR_W-1:0]                         desc_dst_addr,
    input  logic [LEN_W-1:0]                          desc_len,
    input  logic                                      desc_src_nc,
    input  logic                                      desc_dst_nc,
    input  logic                                      slot_grant,
    input  logic                                      line_ret,
    output logic [MAXN-1:0]                           rd_vld,
    output logic [MAXN-1:0][ADDR_W-1:0]               rd_addr,
    output logic [MAXN-1:0][$clog2(LINE_B+1)-1:0]     rd_bytes,
    output logic [MAXN-1:0]                           rd_snoop,
    output logic [MAXN-1:0]                           wr_vld,
    output logic [MAXN-1:0][ADDR_W-1:0]               wr_addr,
    output logic [MAXN-1:0][$clog2(LINE_B+1)-1:0]     wr_bytes,
    output logic [MAXN-1:0]                           wr_snoop,
    output logic                                      done
);
    localparam int CW = $clog2(SLOTS + 1);
    localparam int NW = $clog2(MAXN + 1);
    localparam int BW = $clog2(LINE_B + 1);

    logic          busy, accept, fire, wr_zero, rd_zero_unused;
    logic [NW-1:0] rd_n, wr_n;
    logic [CW-1:0] free_cnt, held_cnt;

    assign fire = slot_grant && busy;

    dls_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (desc_load),
        .wr_zero(wr_zero),
        .busy   (busy),
        .done   (done),
        .accept (accept)
    );

    dls_occ #(.SLOTS(SLOTS), .CW(CW), .NW(NW)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .line_ret(line_ret),
        .free_cnt(free_cnt),
        .held_cnt(held_cnt)
    );

    dls_lane #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_B(LINE_B), .MAXN(MAXN),
               .CW(CW), .NW(NW), .BW(BW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_addr(desc_src_addr),
        .load_len (desc_len),
        .load_nc  (desc_src_nc),
        .fire     (fire),
        .budget   (free_cnt),
        .req_vld  (rd_vld),
        .req_addr (rd_addr),
        .req_bytes(rd_bytes),
        .req_snoop(rd_snoop),
        .n_issue  (rd_n),
        .left_zero(rd_zero_unused)
    );

    dls_lane #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_B(LINE_B), .MAXN(MAXN),
               .CW(CW), .NW(NW), .BW(BW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_addr(desc_dst_addr),
        .load_len (desc_len),
        .load_nc  (desc_dst_nc),
        .fire     (fire),
        .budget   (held_cnt),
        .req_vld  (wr_vld),
        .req_addr (wr_addr),
        .req_bytes(wr_bytes),
        .req_snoop(wr_snoop),
        .n_issue  (wr_n),
        .left_zero(wr_zero)
    );

    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!(|rd_vld) && !(|wr_vld))); // R8
endmodule

// File: tb/dma_line_sched_bench.sv
`timescale 1ns/1ps
module dma_line_sched_bench;
    localparam int AW = 36, LW = 16, LB = 64, MN = 2, SL = 8;

    logic clk = 0, rst_n = 0;
    logic desc_load = 0, desc_src_nc = 0, desc_dst_nc = 0, slot_grant = 0, line_ret = 0;
    logic [AW-1:0] desc_src_addr = '0, desc_dst_addr = '0;
    logic [LW-1:0] desc_len = '0;
    logic [MN-1:0] rd_vld, rd_snoop, wr_vld, wr_snoop;
    logic [MN-1:0][AW-1:0] rd_addr, wr_addr;
    logic [MN-1:0][6:0] rd_bytes, wr_bytes;
    logic done;

    dma_line_sched u_dma_line_sched (.*);

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0;
    bit finished = 0;

    int m_st = 0, m_outs = 0, m_held = 0, m_rleft = 0, m_wleft = 0;
    logic [AW-1:0] m_rptr = '0, m_wptr = '0;
    bit m_snc = 0, m_dnc = 0;
    int e_nrd, e_nwr;
    logic [MN-1:0][AW-1:0] e_raddr, e_waddr;
    int e_rbytes [MN], e_wbytes [MN];
    bit e_rsnp, e_wsnp, e_done;
    string tag9 = "";

    function automatic int min3(int a, int b, int c);
        int m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

    function automatic int lines(int b);
        return (b + LB - 1) / LB;
    endfunction

    function automatic int cap(int b);
        return (b > LB) ? LB : b;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(bit g, bit r, bit ld, logic [AW-1:0] sa, logic [AW-1:0] da,
                       int len, bit snc, bit dnc);
        bit acc, fire;
        if (m_outs == 0) r = 0;
        slot_grant = g; line_ret = r; desc_load = ld;
        desc_src_addr = sa; desc_dst_addr = da; desc_len = LW'(len);
        desc_src_nc = snc; desc_dst_nc = dnc;
        acc  = ld && (m_st != 1);
        fire = g && (m_st == 1);
        tag9 = (ld && m_st == 1) ? " R9" : "";
        e_nrd = fire ? min3(MN, SL - m_outs - m_held, lines(m_rleft)) : 0;
        e_nwr = fire ? min3(MN, m_held, lines(m_wleft)) : 0;
        for (int k = 0; k < MN; k++) begin
            e_raddr[k]  = m_rptr + AW'(k * LB);
            e_waddr[k]  = m_wptr + AW'(k * LB);
            e_rbytes[k] = cap(m_rleft - k * LB);
            e_wbytes[k] = cap(m_wleft - k * LB);
        end
        e_rsnp = !m_snc; e_wsnp = !m_dnc;
        m_outs = m_outs + e_nrd - int'(r);
        m_held = m_held + int'(r) - e_nwr;
        m_rptr = m_rptr + AW'(e_nrd * LB);
        m_wptr = m_wptr + AW'(e_nwr * LB);
        m_rleft = (m_rleft > e_nrd * LB) ? m_rleft - e_nrd * LB : 0;
        if (acc) begin
            m_st = 1; m_rptr = sa; m_wptr = da; m_rleft = len; m_wleft = len;
            m_snc = snc; m_dnc = dnc; m_outs = 0; m_held = 0;
        end else if (m_st == 1 && m_wleft == 0) begin
            m_st = 2;
        end
        if (!acc) m_wleft = (m_wleft > e_nwr * LB) ? m_wleft - e_nwr * LB : 0;
        e_done = (m_st == 2);
        @(posedge clk);
        @(negedge clk);
        chk(rd_vld == MN'((1 << e_nrd) - 1), "R1 R4 rd_vld", rd_vld, (1 << e_nrd) - 1);
        chk(wr_vld == MN'((1 << e_nwr) - 1), "R2 R4 wr_vld", wr_vld, (1 << e_nwr) - 1);
        for (int k = 0; k < MN; k++) begin
            if (k < e_nrd) begin
                chk(rd_addr[k] == e_raddr[k], {"R5 rd_addr", tag9}, rd_addr[k], e_raddr[k]);
                chk(int'(rd_bytes[k]) == e_rbytes[k], "R6 rd_bytes", rd_bytes[k], e_rbytes[k]);
                chk(rd_snoop[k] == e_rsnp, "R7 rd_snoop", rd_snoop[k], e_rsnp);
            end
            if (k < e_nwr) begin
                chk(wr_addr[k] == e_waddr[k], {"R5 wr_addr", tag9}, wr_addr[k], e_waddr[k]);
                chk(int'(wr_bytes[k]) == e_wbytes[k], "R6 wr_bytes", wr_bytes[k], e_wbytes[k]);
                chk(wr_snoop[k] == e_wsnp, "R7 wr_snoop", wr_snoop[k], e_wsnp);
            end
        end
        chk(done == e_done, "R8 done", done, e_done);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int rd_total;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_vld == '0 && wr_vld == '0, "R10 reset valids", {rd_vld, wr_vld}, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);

        // R8: zero-length descriptor
        cyc(0, 0, 1, 36'h1_0000_0000, 36'h2_0000_0000, 0, 0, 0);
        cyc(1, 0, 0, '0, '0, 0, 0, 0);
        chk(done == 1'b1, "R8 zero length done", done, 1);

        // R3: no returns, reads stop at queue depth; R9 load mid-run ignored
        cyc(0, 0, 1, 36'hF_FFFF_FFC0, 36'h0_0000_1003, 2000, 1, 0);
        rd_total = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1, 0, (i == 3), 36'h5_5555_0000, 36'h6_6666_0000, 100, 0, 1);
            rd_total += $countones(rd_vld);
        end
        chk(rd_total == SL, "R3 reads with no returns", rd_total, SL);
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0, '0, 0, 0, 0);
        cyc(1, 0, 0, '0, '0, 0, 0, 0);
        while (m_st != 2) cyc(1, 1, 0, '0, '0, 0, 0, 0);
        cyc(0, 0, 0, '0, '0, 0, 0, 0);

        // random descriptors and slots
        for (int i = 0; i < 6000; i++) begin
            bit ld;
            int len;
            len = (($urandom % 8) == 0) ? int'($urandom % 64) + 1 : int'($urandom % 900);
            ld  = (m_st != 1) ? (($urandom % 4) == 0) : (($urandom % 60) == 0);
            cyc(($urandom % 10) < 7, ($urandom % 2) == 1, ld,
                {4'($urandom), $urandom}, {4'($urandom), $urandom}, len,
                1'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule